// File: doc/BRIEF.md
# Low-Power Mode and Watchdog Supervisor

This block is the mode controller of a system power-management chip. It holds the chip in one of four operating modes: Start-up, Normal, Standby and Sleep. It moves between them on register writes from the host and on wake-up events. It also supervises the host microcontroller with a watchdog that counts a 1 ms enable pulse. When the watchdog overflows, the host gets either an interrupt or a system reset, chosen by a one-shot enable bit.

In Standby, wake-up events from the bus flags, the local wake pin and a rising host supply current become interrupts or resets, as software has configured. A pending interrupt that nobody reads escalates to a reset after a fixed window. If the watchdog-off option is set, the watchdog in Standby runs only while the host draws current above the detection threshold.

In Sleep, the host supply and the external supply enable are both removed and the reset line is held low. The only ways out of Sleep are a bus wake, a falling edge on the wake pin, an overload on the auxiliary switch supply, or a watchdog overflow. Each of these causes a reset into Start-up, and a source code records what caused it.

Top module: `pwr_mode_sup`

## Requirements
- R1: While `rst_n` is low and after it is released, `mode` is 0 (Start-up), `rst_src` is 0 (power-on), `irq_reg` is 0, and both `mcu_sup_en` and `ext_sup_en` are 1. After any reset, including power-on, `sys_rst_n` stays low for RST_CYC clock cycles and then goes high.
- R2: The mode codes are 0 Start-up, 1 Normal, 2 Standby and 3 Sleep. A `mode_wr` strobe is applied only for these steps: 0→1, 1→2, 1→3, 2→1 and 2→3. Every other request is ignored, including a Sleep request from Start-up.
- R3: In Sleep, `sys_rst_n`, `mcu_sup_en` and `ext_sup_en` are all low from the first cycle of the mode.
- R4: The watchdog overflows when the configured period, in ms ticks, has passed since its last restart. A restart is caused by a configuration write, a mode change or a reset. On overflow outside Sleep with `wd_ie` set, `irq_reg` bit 0 is set and no reset happens. With `wd_ie` clear, the overflow causes a reset with source code 1.
- R5: Every watchdog overflow clears `wd_ie`, so the overflow after that causes a reset.
- R6: In Standby with the watchdog-off option set, the watchdog does not run while `icc_above` is low. Once `icc_above` rises, the watchdog starts from zero using the period WD_MAX_MS.
- R7: In Standby, three events count as wake-ups: a rising bus flag (`can_wake` or `lin_wake`), any edge on `loc_wake`, and, with the watchdog-off option set, a rise of `icc_above`. With the wake-response select at 1, these set `irq_reg` bits 1, 2 and 3 respectively. With it at 0, they cause a reset with source codes 2, 3 and 6 respectively.
- R8: An `irq_rd` strobe clears `irq_reg`.
- R9: If `irq_reg` stays non-zero for IRQ_WIN_MS ticks without an `irq_rd`, the block resets with source code 5, enters Start-up and clears `irq_reg`.
- R10: In Sleep, the following events cause a reset into Start-up: a rising bus flag (code 2), a falling edge on `loc_wake` (code 3), and `aux_ovl` (code 4) when `aux_mode` is not 0. A rising edge on `loc_wake` is ignored, and so is `aux_ovl` when `aux_mode` is 0.
- R11: In Sleep with the watchdog-off option set, the watchdog does not run. Otherwise an overflow in Sleep always causes a reset with code 1, whatever `wd_ie` holds, and turns `mcu_sup_en` back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_ms | input | 1 | One-cycle enable pulse, once per millisecond |
| mode_wr | input | 1 | Mode change request strobe |
| mode_req | input | 2 | Requested mode code |
| cfg_wr | input | 1 | Configuration write strobe; also restarts the watchdog |
| cfg_period | input | WD_PW | Watchdog period in ms ticks (0 is treated as 1) |
| cfg_wd_ie | input | 1 | New value of the overflow-interrupt enable |
| cfg_wd_off | input | 1 | Watchdog-off option for Standby and Sleep |
| cfg_wake_irq | input | 1 | Standby wake response: 1 interrupt, 0 reset |
| irq_rd | input | 1 | Clear-on-read strobe of the interrupt register |
| can_wake | input | 1 | CAN bus wake flag |
| lin_wake | input | 1 | LIN bus wake flag |
| loc_wake | input | 1 | Asynchronous local wake pin level (idle high) |
| icc_above | input | 1 | Host supply current at or above threshold |
| aux_ovl | input | 1 | Auxiliary switch supply overload flag |
| aux_mode | input | 2 | Auxiliary supply mode: 0 off, 1 on, 2 or 3 cyclic |
| sys_rst_n | output | 1 | Active-low system reset to the host |
| irq | output | 1 | Interrupt line, high while `irq_reg` is non-zero |
| mcu_sup_en | output | 1 | Host supply enable |
| ext_sup_en | output | 1 | External supply enable (0 means released) |
| wd_ie | output | 1 | Current overflow-interrupt enable |
| mode | output | 2 | Current mode code |
| rst_src | output | 3 | Source code of the most recent reset |
| irq_reg | output | 4 | Interrupt register: bit 0 watchdog, 1 bus, 2 pin, 3 current |

## Verification
The watchdog is exercised in four settings: with the interrupt enable set, with it cleared by an earlier overflow, in Sleep, and under current gating in Standby. Together these separate the interrupt response from the reset response and the normal period from the long one. Each wake source is applied once with the interrupt response and once with the reset response, so that a swapped bit or source code shows up. The Sleep-specific filters are tested with inputs that must be ignored: a rising pin edge and an overload while the auxiliary supply is off. An interrupt is also left unread just short of the window and then past it, which pins down when the escalation happens.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [1:0] {
    PM_START = 2'd0,
    PM_NORM  = 2'd1,
    PM_STBY  = 2'd2,
    PM_SLEEP = 2'd3
  } pms_mode_e;

  typedef enum logic [2:0] {
    RS_POR  = 3'd0,
    RS_WDOG = 3'd1,
    RS_BUS  = 3'd2,
    RS_PIN  = 3'd3,
    RS_AUX  = 3'd4,
    RS_TMO  = 3'd5,
    RS_ICC  = 3'd6
  } pms_src_e;

  localparam int IB_WD  = 0;
  localparam int IB_BUS = 1;
  localparam int IB_PIN = 2;
  localparam int IB_ICC = 3;
  localparam int IRQ_W  = 4;

  localparam int MSW = 16;
  typedef logic [MSW-1:0] pms_ms_t;

  // Legal register-driven mode steps; Sleep is reachable only from Normal or Standby.
  function automatic logic mode_step_ok(pms_mode_e cur, pms_mode_e req);
    logic ok;
    case (cur)
      PM_START: ok = (req == PM_NORM);
      PM_NORM:  ok = (req == PM_STBY) || (req == PM_SLEEP);
      PM_STBY:  ok = (req == PM_NORM) || (req == PM_SLEEP);
      default:  ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Whether the watchdog counts in the given mode.
  function automatic logic wd_active(pms_mode_e m, logic off_opt, logic icc_hi);
    logic run;
    case (m)
      PM_STBY:  run = !off_opt || icc_hi;
      PM_SLEEP: run = !off_opt;
      default:  run = 1'b1;
    endcase
    return run;
  endfunction

  // Overflow limit in ticks: long period under current gating, else programmed value (min 1).
  function automatic pms_ms_t wd_limit(pms_mode_e m, logic off_opt, pms_ms_t per, pms_ms_t longest);
    pms_ms_t lim;
    if (m == PM_STBY && off_opt) lim = longest;
    else if (per == '0)          lim = pms_ms_t'(1);
    else                         lim = per;
    return lim;
  endfunction

  // Auxiliary overload is a wake source only while that supply is on or cycling.
  function automatic logic aux_counts(logic [1:0] aux_m);
    return aux_m != 2'd0;
  endfunction

endpackage

// File: rtl/pms_pin_sync.sv
module pms_pin_sync #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/pms_watchdog.sv
module pms_watchdog #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          run,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          ovf
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == (limit - CW'(1)));
  assign ovf    = run && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (tick) begin
      if (at_end) cnt <= '0;
      else        cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pms_irq_guard.sv
module pms_irq_guard #(
  parameter int WIN = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pending,
  input  logic rd,
  output logic expire
);
  localparam int GW = $clog2(WIN + 1);
  logic [GW-1:0] cnt;

  assign expire = pending && !rd && tick && (cnt == GW'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!pending || rd)   cnt <= '0;
    else if (tick && !expire)  cnt <= cnt + GW'(1);
  end
endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup
  import pms_pkg::*;
#(
  parameter int WD_PW      = 11,
  parameter int WD_MAX_MS  = 1024,
  parameter int WD_INIT_MS = 255,
  parameter int IRQ_WIN_MS = 256,
  parameter int RST_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             mode_wr,
  input  logic [1:0]       mode_req,
  input  logic             cfg_wr,
  input  logic [WD_PW-1:0] cfg_period,
  input  logic             cfg_wd_ie,
  input  logic             cfg_wd_off,
  input  logic             cfg_wake_irq,
  input  logic             irq_rd,
  input  logic             can_wake,
  input  logic             lin_wake,
  input  logic             loc_wake,
  input  logic             icc_above,
  input  logic             aux_ovl,
  input  logic [1:0]       aux_mode,
  output logic             sys_rst_n,
  output logic             irq,
  output logic             mcu_sup_en,
  output logic             ext_sup_en,
  output logic             wd_ie,
  output logic [1:0]       mode,
  output logic [2:0]       rst_src,
  output logic [3:0]       irq_reg
);
  localparam int RCW = $clog2(RST_CYC + 1);

  // State
  pms_mode_e        mode_q;
  pms_src_e         src_q;
  logic [RCW-1:0]   rst_cnt;
  logic [IRQ_W-1:0] irq_q;
  logic             ie_q, off_q, wsel_q, bus_q, icc_q;
  logic [WD_PW-1:0] per_q;

  // Named internal events
  logic             pin_rise, pin_fall, bus_rise, icc_rise;
  logic             in_stby, in_sleep;
  logic             stby_bus, stby_pin, stby_icc;
  logic             slp_bus, slp_pin, aux_evt;
  logic             wd_ovf, wd_as_irq, wd_as_rst, win_expire;
  logic             rst_evt, mode_chg, wd_restart, wd_run, irq_new_any;
  pms_src_e         rst_code;
  pms_mode_e        req_mode;
  pms_ms_t          wd_lim;
  logic [IRQ_W-1:0] irq_set;

  pms_pin_sync #(.IDLE(1'b1)) u_pin (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (loc_wake),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  assign in_stby  = (mode_q == PM_STBY);
  assign in_sleep = (mode_q == PM_SLEEP);
  assign bus_rise = (can_wake | lin_wake) & ~bus_q;
  assign icc_rise = icc_above & ~icc_q;

  assign stby_bus = in_stby & bus_rise;
  assign stby_pin = in_stby & (pin_rise | pin_fall);
  assign stby_icc = in_stby & off_q & icc_rise;
  assign slp_bus  = in_sleep & bus_rise;
  assign slp_pin  = in_sleep & pin_fall;
  assign aux_evt  = in_sleep & aux_ovl & aux_counts(aux_mode);

  assign wd_run = wd_active(mode_q, off_q, icc_above);
  assign wd_lim = wd_limit(mode_q, off_q, pms_ms_t'(per_q), pms_ms_t'(WD_MAX_MS));

  pms_watchdog #(.CW(MSW)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .run    (wd_run),
    .restart(wd_restart),
    .limit  (wd_lim),
    .ovf    (wd_ovf)
  );

  pms_irq_guard #(.WIN(IRQ_WIN_MS)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .pending(irq_q != '0),
    .rd     (irq_rd),
    .expire (win_expire)
  );

  assign wd_as_irq = wd_ovf & ie_q & ~in_sleep;
  assign wd_as_rst = wd_ovf & ~wd_as_irq;

  always_comb begin
    irq_set         = '0;
    irq_set[IB_WD]  = wd_as_irq;
    irq_set[IB_BUS] = stby_bus & wsel_q;
    irq_set[IB_PIN] = stby_pin & wsel_q;
    irq_set[IB_ICC] = stby_icc & wsel_q;
  end
  assign irq_new_any = |irq_set;

  // Reset cause, highest priority first
  always_comb begin
    rst_evt  = 1'b1;
    rst_code = RS_POR;
    if (win_expire)                            rst_code = RS_TMO;
    else if (wd_as_rst)                        rst_code = RS_WDOG;
    else if (aux_evt)                          rst_code = RS_AUX;
    else if (slp_bus || (stby_bus && !wsel_q)) rst_code = RS_BUS;
    else if (slp_pin || (stby_pin && !wsel_q)) rst_code = RS_PIN;
    else if (stby_icc && !wsel_q)              rst_code = RS_ICC;
    else                                       rst_evt  = 1'b0;
  end

  assign req_mode   = pms_mode_e'(mode_req);
  assign mode_chg   = !rst_evt && mode_wr && mode_step_ok(mode_q, req_mode);
  assign wd_restart = cfg_wr | mode_chg | rst_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_START;
      src_q   <= RS_POR;
      rst_cnt <= RCW'(RST_CYC);
      irq_q   <= '0;
      ie_q    <= 1'b0;
      off_q   <= 1'b0;
      wsel_q  <= 1'b0;
      per_q   <= WD_PW'(WD_INIT_MS);
      bus_q   <= 1'b0;
      icc_q   <= 1'b0;
    end else begin
      bus_q <= can_wake | lin_wake;
      icc_q <= icc_above;
      if (cfg_wr) begin
        per_q  <= cfg_period;
        off_q  <= cfg_wd_off;
        wsel_q <= cfg_wake_irq;
      end
      if (wd_ovf)      ie_q <= 1'b0;
      else if (cfg_wr) ie_q <= cfg_wd_ie;
      if (rst_evt) begin
        mode_q  <= PM_START;
        src_q   <= rst_code;
        rst_cnt <= RCW'(RST_CYC);
        irq_q   <= '0;
      end else begin
        if (mode_chg)        mode_q  <= req_mode;
        if (rst_cnt != '0)   rst_cnt <= rst_cnt - RCW'(1);
        irq_q <= (irq_rd ? '0 : irq_q) | irq_set;
      end
    end
  end

  assign sys_rst_n  = !in_sleep && (rst_cnt == '0);
  assign mcu_sup_en = !in_sleep;
  assign ext_sup_en = !in_sleep;
  assign irq        = |irq_q;
  assign wd_ie      = ie_q;
  assign mode       = mode_q;
  assign rst_src    = src_q;
  assign irq_reg    = irq_q;
endmodule

// File: rtl/pms_sva.sv
module pms_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       sys_rst_n,
  input logic       mcu_sup_en,
  input logic       ext_sup_en,
  input logic       wd_ie,
  input logic [2:0] rst_src,
  input logic [3:0] irq_reg,
  input logic       irq_rd,
  input logic       wd_ovf,
  input logic       win_expire,
  input logic       rst_evt,
  input logic       irq_new_any
);
  a_r1_reset_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && $past(rst_evt)) |-> !sys_rst_n);

  a_r2_sleep_entry_from: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> ($past(mode) == 2'd1 || $past(mode) == 2'd2));

  a_r3_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!sys_rst_n && !mcu_sup_en && !ext_sup_en));

  a_r5_ovf_drops_ie: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ovf |=> !wd_ie);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rd && !irq_new_any) |=> (irq_reg == 4'd0));

  a_r9_window_reset: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> (mode == 2'd0 && rst_src == 3'd5 && irq_reg == 4'd0));

  a_r11_sleep_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_ovf && !win_expire && mode == 2'd3) |=> (mode == 2'd0 && rst_src == 3'd1 && mcu_sup_en));
endmodule

bind pwr_mode_sup pms_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .sys_rst_n  (sys_rst_n),
  .mcu_sup_en (mcu_sup_en),
  .ext_sup_en (ext_sup_en),
  .wd_ie      (wd_ie),
  .rst_src    (rst_src),
  .irq_reg    (irq_reg),
  .irq_rd     (irq_rd),
  .wd_ovf     (wd_ovf),
  .win_expire (win_expire),
  .rst_evt    (rst_evt),
  .irq_new_any(irq_new_any)
);

// File: tb/tb_pwr_mode_sup.sv
module tb_pwr_mode_sup;
  localparam int WD_PW = 11;
  localparam int TK    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_req = 2'd0;
  logic cfg_wr = 1'b0;
  logic [WD_PW-1:0] cfg_period = '0;
  logic cfg_wd_ie = 1'b0, cfg_wd_off = 1'b0, cfg_wake_irq = 1'b0;
  logic irq_rd = 1'b0;
  logic can_wake = 1'b0, lin_wake = 1'b0, loc_wake = 1'b1;
  logic icc_above = 1'b0, aux_ovl = 1'b0;
  logic [1:0] aux_mode = 2'd0;
  logic sys_rst_n, irq, mcu_sup_en, ext_sup_en, wd_ie;
  logic [1:0] mode;
  logic [2:0] rst_src;
  logic [3:0] irq_reg;

  int n_tests = 0;
  int n_fail  = 0;
  int    exp_code[$];
  string exp_tag[$];

  pwr_mode_sup #(.WD_PW(WD_PW), .WD_MAX_MS(64), .WD_INIT_MS(255),
                 .IRQ_WIN_MS(256), .RST_CYC(4)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .mode_wr(mode_wr), .mode_req(mode_req),
    .cfg_wr(cfg_wr), .cfg_period(cfg_period), .cfg_wd_ie(cfg_wd_ie), .cfg_wd_off(cfg_wd_off),
    .cfg_wake_irq(cfg_wake_irq), .irq_rd(irq_rd), .can_wake(can_wake), .lin_wake(lin_wake),
    .loc_wake(loc_wake), .icc_above(icc_above), .aux_ovl(aux_ovl), .aux_mode(aux_mode),
    .sys_rst_n(sys_rst_n), .irq(irq), .mcu_sup_en(mcu_sup_en), .ext_sup_en(ext_sup_en),
    .wd_ie(wd_ie), .mode(mode), .rst_src(rst_src), .irq_reg(irq_reg)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (TK - 1) @(negedge clk);
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n * TK) @(negedge clk);
  endtask

  task automatic set_mode(input int m);
    @(negedge clk); mode_wr = 1'b1; mode_req = m[1:0];
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic set_cfg(input int per, input bit ie, input bit off, input bit sel);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_period = per[WD_PW-1:0];
    cfg_wd_ie = ie; cfg_wd_off = off; cfg_wake_irq = sel;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic read_irq();
    @(negedge clk); irq_rd = 1'b1;
    @(negedge clk); irq_rd = 1'b0;
  endtask

  task automatic expect_rst(input int code, input string tag);
    exp_code.push_back(code);
    exp_tag.push_back(tag);
  endtask

  // Scoreboard monitor: each release of the host reset pops one expected cause.
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sys_rst_n && !prev) begin
        if (exp_code.size() == 0) begin
          n_tests++; n_fail++;
          $display("FAIL unexpected reset: actual source %0d expected none", rst_src);
        end else begin
          int    e;
          string t;
          e = exp_code.pop_front();
          t = exp_tag.pop_front();
          chk({t, " reset source"}, int'(rst_src), e);
          chk({t, " mode after reset"}, int'(mode), 0);
        end
      end
      prev = sys_rst_n;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1 power-on state
    expect_rst(0, "R1");
    cyc(5);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 mode", int'(mode), 0);
    chk("R1 irq_reg", int'(irq_reg), 0);
    chk("R1 mcu supply", int'(mcu_sup_en), 1);
    chk("R1 ext supply", int'(ext_sup_en), 1);
    chk("R1 reset held", int'(sys_rst_n), 0);
    cyc(8);
    chk("R1 reset released", int'(sys_rst_n), 1);
    set_cfg(1000, 0, 0, 1);

    // R2 mode steps
    set_mode(3); chk("R2 sleep from startup ignored", int'(mode), 0);
    set_mode(2); chk("R2 standby from startup ignored", int'(mode), 0);
    set_mode(1); chk("R2 startup to normal", int'(mode), 1);
    set_mode(0); chk("R2 startup request ignored", int'(mode), 1);
    set_mode(2); chk("R2 normal to standby", int'(mode), 2);
    set_mode(1); chk("R2 standby to normal", int'(mode), 1);

    // R4 overflow as interrupt, R5 enable cleared
    set_cfg(20, 1, 0, 1);
    ticks(15);
    chk("R4 no overflow before period", int'(irq), 0);
    ticks(7);
    chk("R4 watchdog irq bit", int'(irq_reg), 1);
    chk("R4 no reset on irq overflow", int'(mode), 1);
    chk("R5 enable cleared", int'(wd_ie), 0);
    read_irq();
    chk("R8 read clears", int'(irq_reg), 0);
    set_cfg(20, 0, 0, 1);
    expect_rst(1, "R5");
    ticks(24);
    set_cfg(1000, 0, 0, 1);
    chk("R4 overflow reset to startup", int'(mode), 0);
    set_mode(1);

    // R7 wake as interrupt in Standby
    set_mode(2);
    @(negedge clk); can_wake = 1'b1;
    @(negedge clk); can_wake = 1'b0;
    cyc(2);
    chk("R7 bus wake irq bit", int'(irq_reg), 2);
    chk("R7 irq line", int'(irq), 1);
    read_irq();
    chk("R8 read clears bus bit", int'(irq_reg), 0);
    loc_wake = 1'b0;
    cyc(5);
    chk("R7 pin wake irq bit", int'(irq_reg), 4);
    read_irq();
    icc_above = 1'b1;
    cyc(3);
    chk("R7 current rise ignored without off option", int'(irq_reg), 0);
    icc_above = 1'b0;

    // R9 unread interrupt escalates
    @(negedge clk); lin_wake = 1'b1;
    @(negedge clk); lin_wake = 1'b0;
    cyc(2);
    ticks(250);
    chk("R9 still pending inside window", int'(irq_reg), 2);
    chk("R9 still standby inside window", int'(mode), 2);
    expect_rst(5, "R9");
    ticks(10);
    chk("R9 irq cleared by escalation", int'(irq_reg), 0);

    set_mode(1);
    loc_wake = 1'b1;
    cyc(5);

    // R7 wake as reset in Standby
    set_cfg(1000, 0, 0, 0);
    set_mode(2);
    expect_rst(2, "R7 bus");
    @(negedge clk); lin_wake = 1'b1;
    @(negedge clk); lin_wake = 1'b0;
    cyc(10);
    set_mode(1);
    set_mode(2);
    expect_rst(3, "R7 pin");
    loc_wake = 1'b0;
    cyc(10);
    loc_wake = 1'b1;
    cyc(5);

    // R6 current-gated watchdog in Standby
    set_cfg(1000, 0, 1, 1);
    set_mode(1);
    set_mode(2);
    ticks(100);
    chk("R6 stopped while current low", int'(mode), 2);
    chk("R6 no irq while current low", int'(irq_reg), 0);
    icc_above = 1'b1;
    cyc(3);
    chk("R7 current wake irq bit", int'(irq_reg), 8);
    read_irq();
    ticks(55);
    chk("R6 long period not yet over", int'(mode), 2);
    expect_rst(1, "R6");
    ticks(15);
    chk("R6 overflow after long period", int'(mode), 0);
    icc_above = 1'b0;

    // R7 current wake as reset
    set_cfg(1000, 0, 1, 0);
    set_mode(1);
    set_mode(2);
    expect_rst(6, "R7 current");
    icc_above = 1'b1;
    cyc(5);
    icc_above = 1'b0;
    cyc(5);

    // R3 Sleep outputs, R11 watchdog off in Sleep
    set_mode(1);
    set_mode(3);
    chk("R3 sleep mode", int'(mode), 3);
    chk("R3 reset low", int'(sys_rst_n), 0);
    chk("R3 mcu supply off", int'(mcu_sup_en), 0);
    chk("R3 ext supply released", int'(ext_sup_en), 0);
    ticks(1050);
    chk("R11 watchdog off in sleep", int'(mode), 3);

    // R10 Sleep wake sources
    expect_rst(3, "R10 pin fall");
    loc_wake = 1'b0;
    cyc(10);
    set_mode(1);
    set_mode(3);
    loc_wake = 1'b1;
    cyc(10);
    chk("R10 rising pin ignored", int'(mode), 3);
    aux_mode = 2'd0;
    aux_ovl = 1'b1;
    cyc(5);
    chk("R10 overload ignored with aux off", int'(mode), 3);
    aux_ovl = 1'b0;
    aux_mode = 2'd2;
    cyc(2);
    expect_rst(4, "R10 overload");
    aux_ovl = 1'b1;
    cyc(10);
    aux_ovl = 1'b0;
    set_mode(1);
    set_mode(3);
    expect_rst(2, "R10 bus");
    @(negedge clk); can_wake = 1'b1;
    @(negedge clk); can_wake = 1'b0;
    cyc(10);

    // R11 overflow in Sleep forces reset even with enable set
    set_cfg(30, 1, 0, 1);
    set_mode(1);
    set_mode(3);
    ticks(25);
    chk("R11 sleep before overflow", int'(mode), 3);
    expect_rst(1, "R11");
    ticks(10);
    set_cfg(1000, 0, 0, 1);
    chk("R11 mcu supply back on", int'(mcu_sup_en), 1);
    chk("R5 enable cleared by sleep overflow", int'(wd_ie), 0);

    cyc(20);
    chk("R4 all expected resets observed", exp_code.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule